// File: doc/BRIEF.md
# Fractional Half-Period Clock Divider

This block derives a slower square-wave clock from a fast reference clock when the wanted half-period is not a whole number of reference cycles. With the defaults, a 50 MHz reference gives 1.5 MHz. The ideal half-period there is 16 and 2/3 reference cycles. The block therefore makes each half-period either 16 or 17 reference cycles long and picks between them in a fixed repeating order. Over time the output frequency is exact. Each edge is at most one reference cycle away from its ideal position.

A small remainder register sets the order. It records how much of the fraction has been spent and decides whether the next half-period gets the extra cycle. The output toggles once per half-period, so the nominal duty cycle is 50%. A one-cycle edge strobe lets logic in the reference domain act on each output edge without sampling the divided clock. An enable input freezes the whole divider. A synchronous reset restarts it at the first step of the pattern.

The result is an approximation that carries one reference period of jitter. Where a clean clock is needed, a dedicated PLL is the right tool.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst` is high at a clock edge, `clk_div` and `edge_stb` are 0 after that edge. The internal count and remainder clear, so the next half-period is the first step of the pattern.
- R2: Every half-period of `clk_div` lasts either HALF_WHOLE or HALF_WHOLE+1 enabled reference cycles, which is 16 or 17 by default. An enabled cycle is a rising edge of `clk_ref` with `en` high.
- R3: Half-period k after reset (k counted from 0) gets the extra cycle exactly when ceil((k+1)*FRAC_NUM/FRAC_DEN) - ceil(k*FRAC_NUM/FRAC_DEN) = 1. With the defaults the lengths repeat as 17, 17, 16.
- R4: Every group of FRAC_DEN consecutive half-periods, taken from reset, adds up to FRAC_DEN*HALF_WHOLE + FRAC_NUM enabled cycles. By default that is 50.
- R5: `edge_stb` is high for exactly those clock cycles in which `clk_div` shows a value different from the one it had in the cycle before. Both are registered outputs and change on the same edge.
- R6: A rising edge with `en` low changes neither `clk_div`, the count nor the remainder, and `edge_stb` is 0 after it. When `en` returns, counting resumes where it stopped.
- R7: After reset is released with `en` held high, the first rise of `clk_div` follows the HALF_WHOLE+1-th rising edge. That is the 17th edge by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the divider when high |
| clk_div | output | 1 | Divided clock, registered |
| edge_stb | output | 1 | High in the cycle `clk_div` takes a new value |

## Verification
The bench measures the length of every half-period in enabled cycles and compares it with the ceiling formula. A divider with the pattern in the wrong phase would produce 16, 17, 17 and fail at the first edge. One with a broken remainder update would drift off the 50-cycle group sum. Random gaps in `en` check that a stalled divider does not keep counting or toggling. Such a fault would show up as short half-periods or stray strobes. A reset in the middle of a run must bring back a 17-cycle first half-period, which exposes a remainder that survives reset. A cycle-by-cycle model also catches a strobe that runs one cycle early or late relative to the output edge.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  // Bits needed to hold values 0 .. v-1, never less than one.
  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/frac_rem_acc.sv
module frac_rem_acc #(
  parameter int unsigned FRAC_NUM = 2,
  parameter int unsigned FRAC_DEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic extra
);
  localparam int unsigned RW = fdiv_pkg::bits_for(FRAC_DEN);
  localparam logic [RW-1:0] NUM_V  = RW'(FRAC_NUM);
  localparam logic [RW-1:0] DEN_V  = RW'(FRAC_DEN);
  localparam logic [RW-1:0] COMP_V = RW'(FRAC_DEN - FRAC_NUM);

  logic [RW-1:0] rem;

  // The complement of the fraction is added on every step. A wrap means
  // the half-period is short; no wrap means it gets the extra cycle.
  assign extra = (rem < NUM_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
    end else if (step) begin
      if (rem < NUM_V) rem <= rem + COMP_V;
      else             rem <= rem - NUM_V;
    end
  end

  p_rem_range_r3: assert property (@(posedge clk) disable iff (rst)
    rem < DEN_V);

  p_rem_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(rem));
endmodule

// File: rtl/frac_half_timer.sv
module frac_half_timer #(
  parameter int unsigned HALF_WHOLE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic extra,
  output logic done
);
  localparam int unsigned CW = fdiv_pkg::bits_for(HALF_WHOLE + 1);
  localparam logic [CW-1:0] LAST_LONG  = CW'(HALF_WHOLE);
  localparam logic [CW-1:0] LAST_SHORT = CW'(HALF_WHOLE - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = extra ? LAST_LONG : LAST_SHORT;
  assign done = en && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (done) cnt <= '0;
    else if (en)   cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_LONG);

  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int unsigned HALF_WHOLE = 16,
  parameter int unsigned FRAC_NUM   = 2,
  parameter int unsigned FRAC_DEN   = 3
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic en,
  output logic clk_div,
  output logic edge_stb
);
  logic extra;
  logic done;

  frac_rem_acc #(
    .FRAC_NUM (FRAC_NUM),
    .FRAC_DEN (FRAC_DEN)
  ) i_rem (
    .clk   (clk_ref),
    .rst   (rst),
    .step  (done),
    .extra (extra)
  );

  frac_half_timer #(
    .HALF_WHOLE (HALF_WHOLE)
  ) i_timer (
    .clk   (clk_ref),
    .rst   (rst),
    .en    (en),
    .extra (extra),
    .done  (done)
  );

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      clk_div  <= 1'b0;
      edge_stb <= 1'b0;
    end else begin
      edge_stb <= done;
      if (done) clk_div <= ~clk_div;
    end
  end

  p_stb_edge_r5: assert property (@(posedge clk_ref) disable iff (rst)
    edge_stb |-> (clk_div != $past(clk_div)));

  p_quiet_still_r5: assert property (@(posedge clk_ref) disable iff (rst)
    !edge_stb |-> (clk_div == $past(clk_div)));

  p_idle_no_stb_r6: assert property (@(posedge clk_ref) disable iff (rst)
    !en |=> !edge_stb);

  p_reset_low_r1: assert property (@(posedge clk_ref)
    $past(rst) |-> (!clk_div && !edge_stb));
endmodule

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;
  localparam int CLK_PERIOD = 20;
  localparam int HW  = 16;
  localparam int NUM = 2;
  localparam int DEN = 3;

  logic clk_ref = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic clk_div;
  logic edge_stb;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  frac_clk_div #(.HALF_WHOLE(HW), .FRAC_NUM(NUM), .FRAC_DEN(DEN)) i_frac_clk_div (
    .clk_ref  (clk_ref),
    .rst      (rst),
    .en       (en),
    .clk_div  (clk_div),
    .edge_stb (edge_stb)
  );

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int half_len(input int k);
    return HW + ceil_div((k + 1) * NUM, DEN) - ceil_div(k * NUM, DEN);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model and interval counter, updated on the active edge.
  int  m_cnt = 0, m_k = 0;
  bit  m_out = 0, m_stb = 0;
  int  iv_cnt = 0;
  bit  live = 0;

  always @(posedge clk_ref) begin
    if (rst) begin
      m_cnt <= 0; m_k <= 0; m_out <= 0; m_stb <= 0; iv_cnt <= 0;
    end else if (en) begin
      iv_cnt <= iv_cnt + 1;
      if (m_cnt + 1 == half_len(m_k)) begin
        m_cnt <= 0; m_k <= m_k + 1; m_out <= ~m_out; m_stb <= 1;
      end else begin
        m_cnt <= m_cnt + 1; m_stb <= 0;
      end
    end else begin
      m_stb <= 0;
    end
  end

  // Checks on the falling edge, away from the active edge.
  int iv_idx = 0, grp_sum = 0;
  always @(negedge clk_ref) begin
    if (rst) begin
      iv_idx = 0; grp_sum = 0;
    end else if (live) begin
      check(clk_div == m_out, "R3 R6 clk_div vs model", clk_div, m_out);
      check(edge_stb == m_stb, "R5 R6 edge_stb vs model", edge_stb, m_stb);
      if (edge_stb) begin
        check(iv_cnt == HW || iv_cnt == HW + 1, "R2 half-period range", iv_cnt, HW);
        check(iv_cnt == half_len(iv_idx), "R3 half-period order", iv_cnt, half_len(iv_idx));
        if (iv_idx == 0)
          check(iv_cnt == HW + 1 && clk_div, "R7 first rise", iv_cnt, HW + 1);
        grp_sum += iv_cnt;
        if (iv_idx % DEN == DEN - 1) begin
          check(grp_sum == DEN * HW + NUM, "R4 group sum", grp_sum, DEN * HW + NUM);
          grp_sum = 0;
        end
        iv_idx++;
        iv_cnt = 0;
      end
    end
  end

  task automatic do_reset(input int cycles);
    @(negedge clk_ref);
    rst = 1'b1;
    repeat (cycles) @(negedge clk_ref);
    check(clk_div == 1'b0, "R1 reset clk_div", clk_div, 0);
    check(edge_stb == 1'b0, "R1 reset edge_stb", edge_stb, 0);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    live = 1;
    do_reset(4);
    // Directed: continuous enable for 12 half-periods.
    en = 1'b1;
    repeat (12 * (HW + 1)) @(negedge clk_ref);
    // Directed: long stall, output must hold.
    en = 1'b0;
    begin
      bit held;
      held = clk_div;
      repeat (25) @(negedge clk_ref);
      check(clk_div == held, "R6 hold during stall", clk_div, held);
      check(edge_stb == 1'b0, "R6 no strobe during stall", edge_stb, 0);
    end
    // Random enable pattern.
    for (int i = 0; i < 3000; i++) begin
      en = ($urandom % 10) < 7;
      @(negedge clk_ref);
    end
    // Reset in mid-run, then the pattern must restart at its first step.
    do_reset(2);
    en = 1'b1;
    repeat (HW) @(negedge clk_ref);
    check(clk_div == 1'b0, "R7 no rise before edge 17", clk_div, 0);
    @(negedge clk_ref);
    check(clk_div == 1'b1, "R1 R7 rise after restart", clk_div, 1);
    for (int i = 0; i < 2000; i++) begin
      en = ($urandom % 4) != 0;
      @(negedge clk_ref);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_ref);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule